// File: doc/BRIEF.md
# Power Mode and System Clock Controller

This block sets the power state of a mixed-domain interface device and chooses the source of its system clock. Software writes three power-control bits, a clock-source request bit and a PLL-code byte through a simple address/data write strobe. A combinational read port returns those registers together with a synchronized lock indicator and a sticky lock-loss flag. The write and read port stays usable in every power state.

From the register contents the block drives several controls: an enable for the far-side front end and its barrier link, a PLL enable, an output enable for the PCM transmit-data and timeslot-control pins, and a run gate for the PCM engine. It also produces a system clock. After reset the system clock is the PCM bit clock. When software asks for the PLL and the PLL reports lock, the clock switches to the PLL output. Each direction of the switch is a two-stage handoff that is synchronized in the clock domain it affects, so no pulse is ever cut short. If lock is lost while the PLL is the source, the block returns to the bit clock by itself and records the event.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset, register 0x0F reads 0x80, register 0x0E reads 0x00 and register 0x0D reads 0x00 while lock is low. `feEn`, `pllEn`, `pinOe` and `pcmRun` are all 1, and `sysClk` follows `pcmClk`.
- R2: Register 0x0F holds front-end enable in bit 7, power-down in bit 6 and sleep in bit 5. Its other bits always read 0. Register 0x0D bit 7 is read-only, and writing it has no effect.
- R3: While power-down (0x0F bit 6) is 1, `feEn`, `pllEn`, `pinOe` and `pcmRun` are all 0. The registers keep their contents and stay readable and writable.
- R4: While sleep (0x0F bit 5) is 1 and power-down is 0, `pllEn`, `pinOe` and `pcmRun` are 0, `feEn` follows 0x0F bit 7, and `sysClk` follows `pcmClk`.
- R5: When 0x0F bit 7 is 0, `feEn` is 0 and `pllEn`, `pinOe` and `pcmRun` are unaffected.
- R6: When power-down and sleep are both 1, the power-down behaviour of R3 applies, so `feEn` is 0 even with bit 7 set.
- R7: The clock-select bit (0x0E bit 7) is forced to 0 whenever sleep or power-down is 1. A write of 1 to it during those states reads back 0 and leaves `sysClk` on `pcmClk`.
- R8: With 0x0E bit 7 set to 1, `sysClk` moves to `pllClk` only while `pllLock` is 1, and otherwise stays on `pcmClk`. Writing 0 moves it back to `pcmClk`.
- R9: No high or low phase of `sysClk` is shorter than the shorter half period of `pcmClk` and `pllClk`, including across every source change.
- R10: If `pllLock` falls while 0x0E bit 7 is 1, the bit clears, `sysClk` returns to `pcmClk` and the sticky flag at 0x0D bit 6 is set. The flag stays set until a 1 is written to 0x0D bit 6.
- R11: After a power-down, `pcmRun` stays 0 until the PLL-code register (address 0x10 by default) is written. The written value reads back unchanged.
- R12: Register 0x0D bit 7 reads the level of `pllLock` within three `clk` cycles after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 8 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 8 | Read address |
| rdData | output | 8 | Read data, combinational from `rdAddr` |
| pcmClk | input | 1 | PCM bit clock |
| pllClk | input | 1 | PLL output clock |
| pllLock | input | 1 | Asynchronous PLL lock indication |
| sysClk | output | 1 | Selected system clock |
| feEn | output | 1 | Far-side front end and barrier link enable |
| pllEn | output | 1 | PLL enable |
| pinOe | output | 1 | Output enable for PCM transmit-data and timeslot-control pins |
| pcmRun | output | 1 | PCM engine run gate |

## Verification
The clock source is exercised with four patterns:
- the request with lock held low, which separates a lock-qualified switch from one that follows the request bit alone;
- the request with lock high;
- an explicit return to the bit clock;
- a lock drop while the PLL is the source, which separates the automatic fallback from a switch that only software can undo.

Every `sysClk` edge is time-stamped throughout these changes, so a handoff that cuts a phase short is seen as a pulse narrower than the fast source's half period. The source is identified from the edge count in a fixed window, because the two sources differ by a factor of more than six. The power patterns (front end off, sleep, power-down, and sleep plus power-down) are set apart by which outputs fall and by what the clock-select bit and the run gate do after each exit.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_W  = 8;
  // control register bit positions
  localparam int FE_POS = 7;
  localparam int PD_POS = 6;
  localparam int SL_POS = 5;
  // clock-select register bit position
  localparam int CS_POS = 7;
  // status register bit positions
  localparam int LK_POS = 7;
  localparam int LL_POS = 6;

  // strobes from control to the clock/drive datapath
  typedef struct packed {
    logic reqPll;
    logic feOn;
    logic pllOn;
    logic pinOn;
    logic runOn;
  } pmcCmd_t;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int STAGES   = 2,
  parameter bit RST_VAL  = 1'b0,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (NEG_EDGE) begin : gNeg
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
      end
    end else begin : gPos
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0F,
  parameter logic [ADDR_W-1:0] CSEL_ADDR = 'h0E,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0D,
  parameter logic [ADDR_W-1:0] CODE_ADDR = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              lockSync,
  output pmcCmd_t           cmd,
  output logic              pwdnOn,
  output logic              sleepOn,
  output logic              selBit,
  output logic              lossFlag
);
  logic feBit, pwdnBit, sleepBit, pend, lockPrev;
  logic [REG_W-1:0] codeReg;

  logic wCtrl, wSel, wStat, wCode;
  logic feNext, pdNext, slNext, selNext, lossNext, pendNext;
  logic offNext, lockFall, awake;

  assign wCtrl = wrEn && (wrAddr == CTRL_ADDR);
  assign wSel  = wrEn && (wrAddr == CSEL_ADDR);
  assign wStat = wrEn && (wrAddr == STAT_ADDR);
  assign wCode = wrEn && (wrAddr == CODE_ADDR);

  assign lockFall = lockPrev && !lockSync;

  always_comb begin
    feNext  = wCtrl ? wrData[FE_POS] : feBit;
    pdNext  = wCtrl ? wrData[PD_POS] : pwdnBit;
    slNext  = wCtrl ? wrData[SL_POS] : sleepBit;
    offNext = pdNext || slNext;

    // forcing wins over software, fallback wins over a same-cycle write
    if (offNext)                  selNext = 1'b0;
    else if (selBit && lockFall)  selNext = 1'b0;
    else if (wSel)                selNext = wrData[CS_POS];
    else                          selNext = selBit;

    // setting wins over clearing
    if (selBit && lockFall)             lossNext = 1'b1;
    else if (wStat && wrData[LL_POS])   lossNext = 1'b0;
    else                                lossNext = lossFlag;

    // armed on entry into power-down, released by any code write
    if (wCode)                  pendNext = 1'b0;
    else if (!pwdnBit && pdNext) pendNext = 1'b1;
    else                        pendNext = pend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      feBit    <= 1'b1;
      pwdnBit  <= 1'b0;
      sleepBit <= 1'b0;
      selBit   <= 1'b0;
      lossFlag <= 1'b0;
      pend     <= 1'b0;
      lockPrev <= 1'b0;
      codeReg  <= '0;
    end else begin
      feBit    <= feNext;
      pwdnBit  <= pdNext;
      sleepBit <= slNext;
      selBit   <= selNext;
      lossFlag <= lossNext;
      pend     <= pendNext;
      lockPrev <= lockSync;
      if (wCode) codeReg <= wrData;
    end
  end

  assign awake = !pwdnBit && !sleepBit;

  always_comb begin
    cmd.feOn   = feBit && !pwdnBit;
    cmd.pllOn  = awake;
    cmd.pinOn  = awake;
    cmd.runOn  = awake && !pend;
    cmd.reqPll = selBit && lockSync && awake;
  end

  assign pwdnOn  = pwdnBit;
  assign sleepOn = sleepBit;

  always_comb begin
    rdData = '0;
    if (rdAddr == CTRL_ADDR) begin
      rdData[FE_POS] = feBit;
      rdData[PD_POS] = pwdnBit;
      rdData[SL_POS] = sleepBit;
    end else if (rdAddr == CSEL_ADDR) begin
      rdData[CS_POS] = selBit;
    end else if (rdAddr == STAT_ADDR) begin
      rdData[LK_POS] = lockSync;
      rdData[LL_POS] = lossFlag;
    end else if (rdAddr == CODE_ADDR) begin
      rdData = codeReg;
    end
  end
endmodule

// File: rtl/pmc_clkpath.sv
module pmc_clkpath
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pcmClk,
  input  logic    pllClk,
  input  logic    pllLock,
  input  pmcCmd_t cmd,
  output logic    lockSync,
  output logic    sysClk,
  output logic    feEn,
  output logic    pllEn,
  output logic    pinOe,
  output logic    pcmRun
);
  logic pcmGate, pllGate, pcmWant, pllWant;

  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .NEG_EDGE(1'b0)) uLockSync (
    .clk(clk), .rstN(rstN), .d(pllLock), .q(lockSync)
  );

  // each side opens only after the other side has closed
  assign pllWant = cmd.reqPll && !pcmGate;
  assign pcmWant = !cmd.reqPll && !pllGate;

  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .NEG_EDGE(1'b1)) uPllSide (
    .clk(pllClk), .rstN(rstN), .d(pllWant), .q(pllGate)
  );

  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .NEG_EDGE(1'b1)) uPcmSide (
    .clk(pcmClk), .rstN(rstN), .d(pcmWant), .q(pcmGate)
  );

  assign sysClk = (pcmClk & pcmGate) | (pllClk & pllGate);

  assign feEn   = cmd.feOn;
  assign pllEn  = cmd.pllOn;
  assign pinOe  = cmd.pinOn;
  assign pcmRun = cmd.runOn;
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pmc_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h0F,
  parameter logic [ADDR_W-1:0] CSEL_ADDR   = 'h0E,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 'h0D,
  parameter logic [ADDR_W-1:0] CODE_ADDR   = 'h10,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              pcmClk,
  input  logic              pllClk,
  input  logic              pllLock,
  output logic              sysClk,
  output logic              feEn,
  output logic              pllEn,
  output logic              pinOe,
  output logic              pcmRun
);
  pmcCmd_t cmd;
  logic    lockSync, pwdnOn, sleepOn, selBit, lossFlag;

  pmc_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CSEL_ADDR(CSEL_ADDR),
    .STAT_ADDR(STAT_ADDR), .CODE_ADDR(CODE_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .lockSync(lockSync), .cmd(cmd),
    .pwdnOn(pwdnOn), .sleepOn(sleepOn), .selBit(selBit), .lossFlag(lossFlag)
  );

  pmc_clkpath #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .pcmClk(pcmClk), .pllClk(pllClk), .pllLock(pllLock),
    .cmd(cmd), .lockSync(lockSync), .sysClk(sysClk), .feEn(feEn),
    .pllEn(pllEn), .pinOe(pinOe), .pcmRun(pcmRun)
  );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0D
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              lossClr,
  input logic              feEn,
  input logic              pllEn,
  input logic              pinOe,
  input logic              pcmRun,
  input logic              pwdnOn,
  input logic              sleepOn,
  input logic              selBit,
  input logic              lossFlag,
  input logic              lockSync
);
  a_r3_pwdn_all_off: assert property (@(posedge clk) disable iff (!rstN)
    pwdnOn |-> (!feEn && !pllEn && !pinOe && !pcmRun));

  a_r4_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    sleepOn |-> (!pllEn && !pinOe && !pcmRun));

  a_r7_sel_forced: assert property (@(posedge clk) disable iff (!rstN)
    (pwdnOn || sleepOn) |-> !selBit);

  a_r10_loss_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lossFlag && !(wrEn && wrAddr == STAT_ADDR && lossClr)) |=> lossFlag);

  a_r10_fallback: assert property (@(posedge clk) disable iff (!rstN)
    (selBit && $fell(lockSync)) |=> (!selBit && lossFlag));
endmodule

bind pwr_clk_ctrl pmc_checker #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .lossClr(wrData[pmc_pkg::LL_POS]), .feEn(feEn), .pllEn(pllEn),
  .pinOe(pinOe), .pcmRun(pcmRun), .pwdnOn(pwdnOn), .sleepOn(sleepOn),
  .selBit(selBit), .lossFlag(lossFlag), .lockSync(lockSync)
);

// File: tb/sim_pwr_clk_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_clk_ctrl;
  logic       clk = 1'b0, rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0, wrData = '0, rdAddr = '0;
  logic [7:0] rdData;
  logic       pcmClk = 1'b0, pllClk = 1'b0, pllLock = 1'b0;
  logic       sysClk, feEn, pllEn, pinOe, pcmRun;

  int  total = 0, bad = 0;
  bit  done = 1'b0;

  always #10 clk    = ~clk;   // 50 MHz
  always #40 pcmClk = ~pcmClk; // half period 40 ns
  always #6  pllClk = ~pllClk; // half period 6 ns

  pwr_clk_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pcmClk(pcmClk), .pllClk(pllClk),
    .pllLock(pllLock), .sysClk(sysClk), .feEn(feEn), .pllEn(pllEn),
    .pinOe(pinOe), .pcmRun(pcmRun)
  );

  // sysClk pulse-width monitor and edge counter
  realtime lastEdge = 0.0, minW = 1.0e9;
  bit      monOn = 1'b0, cntOn = 1'b0;
  int      edgeCnt = 0;
  always @(posedge sysClk or negedge sysClk) begin
    if (monOn && lastEdge > 0.0 && ($realtime - lastEdge) < minW)
      minW = $realtime - lastEdge;
    lastEdge = $realtime;
  end
  always @(posedge sysClk) if (cntOn) edgeCnt++;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input string what,
                          input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic countEdges(output int n);
    #1000;
    edgeCnt = 0;
    cntOn = 1'b1;
    #2000;
    cntOn = 1'b0;
    n = edgeCnt;
  endtask

  task automatic chkOuts(input string req, input logic f, input logic p,
                         input logic o, input logic r);
    chk(req, "feEn",   feEn,   f);
    chk(req, "pllEn",  pllEn,  p);
    chk(req, "pinOe",  pinOe,  o);
    chk(req, "pcmRun", pcmRun, r);
  endtask

  // R1
  task automatic tReset();
    logic [7:0] v;
    int n;
    rd(8'h0F, v); chk("R1", "ctrl reg", v, 8'h80);
    rd(8'h0E, v); chk("R1", "csel reg", v, 8'h00);
    rd(8'h0D, v); chk("R1", "status reg", v, 8'h00);
    chkOuts("R1", 1, 1, 1, 1);
    countEdges(n); chkRange("R1", "sysClk edges (pcm)", n, 20, 30);
  endtask

  // R2, R11 readback
  task automatic tRegMap();
    logic [7:0] v;
    wr(8'h0F, 8'h9F);
    rd(8'h0F, v); chk("R2", "ctrl low bits read zero", v, 8'h80);
    wr(8'h0D, 8'h80);
    rd(8'h0D, v); chk("R2", "lock bit not writable", v, 8'h00);
    wr(8'h10, 8'h5A);
    rd(8'h10, v); chk("R11", "code readback", v, 8'h5A);
    chkOuts("R2", 1, 1, 1, 1);
  endtask

  // R5
  task automatic tFrontEnd();
    wr(8'h0F, 8'h00);
    chkOuts("R5", 0, 1, 1, 1);
    wr(8'h0F, 8'h80);
    chkOuts("R5", 1, 1, 1, 1);
  endtask

  // R4
  task automatic tSleep();
    logic [7:0] v;
    int n;
    wr(8'h0F, 8'hA0);
    chkOuts("R4", 1, 0, 0, 0);
    rd(8'h0F, v); chk("R4", "ctrl reg in sleep", v, 8'hA0);
    countEdges(n); chkRange("R4", "sysClk edges in sleep", n, 20, 30);
    wr(8'h0F, 8'h20);
    chkOuts("R4", 0, 0, 0, 0);
    wr(8'h0F, 8'h80);
    chkOuts("R4", 1, 1, 1, 1);
  endtask

  // R3, R6, R7, R11
  task automatic tPowerDown();
    logic [7:0] v;
    wr(8'h0F, 8'hE0);
    chkOuts("R6", 0, 0, 0, 0);
    rd(8'h0F, v); chk("R3", "ctrl reg kept", v, 8'hE0);
    rd(8'h10, v); chk("R3", "code kept in power-down", v, 8'h5A);
    wr(8'h0F, 8'hC0);
    rd(8'h0F, v); chk("R3", "ctrl writable in power-down", v, 8'hC0);
    chkOuts("R3", 0, 0, 0, 0);
    wr(8'h0E, 8'h80);
    rd(8'h0E, v); chk("R7", "select forced in power-down", v, 8'h00);
    wr(8'h0F, 8'h80);
    chk("R11", "pcmRun held after exit", pcmRun, 1'b0);
    chk("R11", "pllEn after exit", pllEn, 1'b1);
    repeat (10) @(negedge clk);
    chk("R11", "pcmRun still held", pcmRun, 1'b0);
    wr(8'h10, 8'h33);
    chk("R11", "pcmRun after code write", pcmRun, 1'b1);
    rd(8'h10, v); chk("R11", "new code readback", v, 8'h33);
  endtask

  // R8, R9, R12
  task automatic tClkSwitch();
    logic [7:0] v;
    int n;
    minW = 1.0e9; monOn = 1'b1;
    pllLock = 1'b0;
    wr(8'h0E, 8'h80);
    rd(8'h0E, v); chk("R8", "select bit set", v, 8'h80);
    countEdges(n); chkRange("R8", "no switch without lock", n, 20, 30);
    pllLock = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h0D, v); chk("R12", "lock indicator high", v, 8'h80);
    countEdges(n); chkRange("R8", "sysClk edges (pll)", n, 150, 175);
    wr(8'h0E, 8'h00);
    countEdges(n); chkRange("R8", "back to pcm", n, 20, 30);
    wr(8'h0E, 8'h80);
    countEdges(n); chkRange("R8", "pll again", n, 150, 175);
    total++;
    if (minW < 5.9) begin
      bad++;
      $display("FAIL R9 min pulse actual=%0.2f expected>=6.00", minW);
    end
  endtask

  // R10, R12
  task automatic tLockLoss();
    logic [7:0] v;
    int n;
    pllLock = 1'b0;
    repeat (6) @(negedge clk);
    rd(8'h0E, v); chk("R10", "select cleared", v, 8'h00);
    rd(8'h0D, v); chk("R10", "loss flag set, lock low", v, 8'h40);
    countEdges(n); chkRange("R10", "fallback to pcm", n, 20, 30);
    pllLock = 1'b1;
    repeat (6) @(negedge clk);
    rd(8'h0D, v); chk("R10", "flag sticky after relock", v, 8'hC0);
    countEdges(n); chkRange("R10", "stays on pcm after relock", n, 20, 30);
    wr(8'h0D, 8'h00);
    rd(8'h0D, v); chk("R10", "write 0 leaves flag", v, 8'hC0);
    wr(8'h0D, 8'h40);
    rd(8'h0D, v); chk("R10", "write 1 clears flag", v, 8'h80);
    total++;
    if (minW < 5.9) begin
      bad++;
      $display("FAIL R9 min pulse after fallback actual=%0.2f expected>=6.00", minW);
    end
  endtask

  // R7 via sleep
  task automatic tSleepClearsSel();
    logic [7:0] v;
    int n;
    wr(8'h0E, 8'h80);
    countEdges(n); chkRange("R7", "pll before sleep", n, 150, 175);
    wr(8'h0F, 8'hA0);
    rd(8'h0E, v); chk("R7", "select cleared by sleep", v, 8'h00);
    countEdges(n); chkRange("R7", "pcm in sleep", n, 20, 30);
    wr(8'h0F, 8'h80);
    rd(8'h0E, v); chk("R7", "select stays 0 after wake", v, 8'h00);
    monOn = 1'b0;
    total++;
    if (minW < 5.9) begin
      bad++;
      $display("FAIL R9 min pulse over sleep actual=%0.2f expected>=6.00", minW);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    tReset();
    tRegMap();
    tFrontEnd();
    tSleep();
    tPowerDown();
    tClkSwitch();
    tLockLoss();
    tSleepClearsSel();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule